// File: doc/BRIEF.md
# Freezable Circular Event Trace Buffer

This block is an on-chip event recorder. Event words arrive on a valid/ready stream and are stored in a circular memory of 128 entries, each 64 bits wide. A host controls the block through one 32-bit control/status word and reads stored entries through a separate 64-bit data port. Once the memory wraps, capture overwrites the oldest entry. The block keeps no overflow indication.

The host uses the control word to set the capture enable and the capture mode, and to load a read pointer. The same word reports the capture write pointer and a pair-complete flag. Clearing the enable freezes capture: the memory, the write pointer and the flag then hold their values. While frozen, the host can dump the whole buffer from oldest to newest by stepping the read pointer modulo 128. Setting the enable again resumes capture at the point where it stopped. Modes 0 and 1 store one 64-bit event per entry. Modes 2 and 3 pack two 32-bit samples into each entry: the first sample goes into the low half and the second into the high half.

Stream rules: an event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` equals the capture enable, so the source must hold `ev_data` until the enable returns while capture is frozen. A read through the data port while capture is running returns whatever the memory holds at that moment, with no coherency guarantee.

Top module: `evt_trace_buf`

## Requirements
- R1: After reset, the control word reads 32'h0080_0000: enable 0, mode 0, both pointers 0 and pair-complete flag 1. `ev_ready` is 0.
- R2: The control word has this layout: read pointer in bits 6:0, enable at bit 12, mode in bits 15:14, write pointer in bits 22:16, pair-complete flag at bit 23. All other bits read 0. A host write loads the read pointer, the enable and the mode from the matching bits.
- R3: In modes 0 and 1, each accepted event is stored whole at the entry the write pointer selects, and the write pointer then advances by one. The flag reads 1.
- R4: In modes 2 and 3, the first accepted sample (bits 31:0 of `ev_data`) goes into the low half of the entry at the write pointer, the flag becomes 0 and the write pointer holds. The next sample goes into the high half of the same entry, the flag becomes 1 and the write pointer advances by one.
- R5: While the enable is 0, `ev_ready` is 0 and no event is accepted. The memory, the write pointer and the flag do not change.
- R6: After the enable is set again, the next accepted event goes into the entry at the held write pointer.
- R7: Host writes to the control word never change the write pointer or the flag.
- R8: The write pointer wraps from 127 to 0, and capture overwrites the entries it passes. Entries not yet overwritten keep their contents.
- R9: From the cycle after a host write, `dat_rdata` returns the entry selected by the read pointer that was written.
- R10: In modes 2 and 3, flag 0 means the entry at the write pointer is incomplete. The oldest valid entry is then at the write pointer plus one, so a reader can start a dump there and discard the last entry it reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event word is offered |
| ev_ready | output | 1 | Block accepts events (equals capture enable) |
| ev_data | input | 64 | Event word; only bits 31:0 are used in modes 2 and 3 |
| cfg_we | input | 1 | Host write strobe for the control word |
| cfg_wdata | input | 32 | Host write data for the control word |
| cfg_rdata | output | 32 | Current control/status word |
| dat_rdata | output | 64 | Entry selected by the read pointer |

## Verification
Assertions placed in the RTL check the pointer and flag stepping on every cycle: a single-step advance per event in the whole-entry modes, the hold-then-advance pattern of the pair modes, status that stays unchanged without an accepted event, and the loading of the host fields. Other behaviours can only be shown through the bench's scenarios. These are the data stored in each half of an entry, the fact that frozen stimulus leaves no trace, overwrite after a wrap, and an oldest-first dump starting past an incomplete pair.

// File: rtl/evt_trace_pkg.sv
package evt_trace_pkg;
  // Control word bit positions (a host decodes these)
  localparam int unsigned CW_RPTR_LSB = 0;
  localparam int unsigned CW_EN_BIT   = 12;
  localparam int unsigned CW_MODE_LSB = 14;
  localparam int unsigned CW_WPTR_LSB = 16;
  localparam int unsigned CW_DONE_BIT = 23;
  localparam int unsigned CW_WIDTH    = 32;

  typedef enum logic [1:0] {
    CAP_WHOLE_A = 2'd0,
    CAP_WHOLE_B = 2'd1,
    CAP_PAIR_A  = 2'd2,
    CAP_PAIR_B  = 2'd3
  } cap_mode_e;

  function automatic logic is_pair(input cap_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/evt_trace_cfg.sv
module evt_trace_cfg
  import evt_trace_pkg::*;
#(
  parameter int unsigned PTR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CW_WIDTH-1:0] cfg_wdata,
  output logic                cap_en,
  output cap_mode_e           cap_mode,
  output logic [PTR_W-1:0]    rd_ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en   <= 1'b0;
      cap_mode <= CAP_WHOLE_A;
      rd_ptr   <= '0;
    end else if (cfg_we) begin
      cap_en   <= cfg_wdata[CW_EN_BIT];
      cap_mode <= cap_mode_e'(cfg_wdata[CW_MODE_LSB +: 2]);
      rd_ptr   <= cfg_wdata[CW_RPTR_LSB +: PTR_W];
    end
  end

  // R2: host fields load from their bit positions
  a_r2_rptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> rd_ptr == $past(cfg_wdata[CW_RPTR_LSB +: PTR_W]));
  a_r2_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cap_en == $past(cfg_wdata[CW_EN_BIT]));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(rd_ptr) && $stable(cap_en) && $stable(cap_mode));
endmodule

// File: rtl/evt_trace_wr.sv
module evt_trace_wr
  import evt_trace_pkg::*;
#(
  parameter int unsigned PTR_W   = 7,
  parameter int unsigned ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  cap_mode_e          cap_mode,
  input  logic [ENTRY_W-1:0] ev_data,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic               pair_done,
  output logic [1:0]         lane_we,
  output logic [ENTRY_W-1:0] wr_data
);
  localparam int unsigned HALF_W = ENTRY_W / 2;

  logic pair;
  assign pair = is_pair(cap_mode);

  always_comb begin
    lane_we = 2'b00;
    wr_data = ev_data;
    if (accept) begin
      if (!pair) begin
        lane_we = 2'b11;
      end else begin
        wr_data = {ev_data[HALF_W-1:0], ev_data[HALF_W-1:0]};
        lane_we = pair_done ? 2'b01 : 2'b10;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      pair_done <= 1'b1;
    end else if (accept) begin
      if (!pair) begin
        wr_ptr    <= wr_ptr + 1'b1;
        pair_done <= 1'b1;
      end else if (pair_done) begin
        pair_done <= 1'b0;
      end else begin
        wr_ptr    <= wr_ptr + 1'b1;
        pair_done <= 1'b1;
      end
    end
  end

  // R3: whole-entry modes step once per event
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pair) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)) && pair_done);
  // R4: first sample of a pair holds the pointer
  a_r4_pair_open: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pair && pair_done) |=> $stable(wr_ptr) && !pair_done);
  // R4: second sample closes the pair and advances
  a_r4_pair_close: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pair && !pair_done) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)) && pair_done);
  // R5, R7: no accepted event, no status change
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(wr_ptr) && $stable(pair_done));
  a_r5_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> lane_we == 2'b00);
endmodule

// File: rtl/evt_trace_mem.sv
module evt_trace_mem #(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned HALF_W = ENTRY_W / 2
) (
  input  logic               clk,
  input  logic [1:0]         lane_we,
  input  logic [PTR_W-1:0]   wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [PTR_W-1:0]   rd_addr,
  output logic [ENTRY_W-1:0] rd_data
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HALF_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) store[wr_addr] <= wr_data[g*HALF_W +: HALF_W];
    end
    assign rd_data[g*HALF_W +: HALF_W] = store[rd_addr];
  end
endmodule

// File: rtl/evt_trace_buf.sv
module evt_trace_buf
  import evt_trace_pkg::*;
#(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [ENTRY_W-1:0]  ev_data,
  input  logic                cfg_we,
  input  logic [CW_WIDTH-1:0] cfg_wdata,
  output logic [CW_WIDTH-1:0] cfg_rdata,
  output logic [ENTRY_W-1:0]  dat_rdata
);
  logic             cap_en;
  cap_mode_e        cap_mode;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic             pair_done;
  logic [1:0]       lane_we;
  logic [ENTRY_W-1:0] wr_data;
  logic             accept;

  assign ev_ready = cap_en;
  assign accept   = ev_valid && cap_en;

  evt_trace_cfg #(.PTR_W(PTR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cap_en(cap_en), .cap_mode(cap_mode), .rd_ptr(rd_ptr)
  );

  evt_trace_wr #(.PTR_W(PTR_W), .ENTRY_W(ENTRY_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cap_mode(cap_mode),
    .ev_data(ev_data), .wr_ptr(wr_ptr), .pair_done(pair_done),
    .lane_we(lane_we), .wr_data(wr_data)
  );

  evt_trace_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_mem (
    .clk(clk), .lane_we(lane_we), .wr_addr(wr_ptr), .wr_data(wr_data),
    .rd_addr(rd_ptr), .rd_data(dat_rdata)
  );

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[CW_RPTR_LSB +: PTR_W] = rd_ptr;
    cfg_rdata[CW_EN_BIT]            = cap_en;
    cfg_rdata[CW_MODE_LSB +: 2]     = cap_mode;
    cfg_rdata[CW_WPTR_LSB +: PTR_W] = wr_ptr;
    cfg_rdata[CW_DONE_BIT]          = pair_done;
  end

  // R5: a frozen block must not take writes into memory
  a_r5_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> lane_we == 2'b00);
  // R7: a host write alone leaves status untouched
  a_r7_cfg_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !accept) |=> $stable(wr_ptr) && $stable(pair_done));
endmodule

// File: tb/evt_trace_buf_bench.sv
module evt_trace_buf_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [63:0] ev_data = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] dat_rdata;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_trace_buf u_evt_trace_buf (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dat_rdata(dat_rdata)
  );

  // stimulus event and expected write pointer after it
  localparam logic [63:0] VEC_DATA [8] = '{
    64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_0001,
    64'h8000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_5555_AAAA,
    64'h0F0F_0F0F_F0F0_F0F0, 64'h1357_9BDF_2468_ACE0 };
  localparam logic [6:0] VEC_WPTR [8] = '{7'd1, 7'd2, 7'd3, 7'd4, 7'd5, 7'd6, 7'd7, 7'd8};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic en, input logic [1:0] mode, input logic [6:0] rp);
    ctl = '0;
    ctl[6:0] = rp;
    ctl[12] = en;
    ctl[15:14] = mode;
  endfunction

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [63:0] d);
    @(negedge clk); ev_valid = 1'b1; ev_data = d;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  logic       cur_en = 1'b0;
  logic [1:0] cur_mode = 2'd0;

  task automatic read_entry(input logic [6:0] idx, output logic [63:0] d);
    cfg_write(ctl(cur_en, cur_mode, idx));
    d = dat_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", 64'(cfg_rdata), 64'h0080_0000);
    check("R1 ready", 64'(ev_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field layout
    cur_en = 1'b1; cur_mode = 2'd0;
    cfg_write(ctl(1'b1, 2'd0, 7'd5));
    check("R2 cfg", 64'(cfg_rdata), 64'h0080_1005);
    check("R2 ready", 64'(ev_ready), 64'd1);

    // R3 table walk, whole-entry mode
    for (int i = 0; i < 8; i++) begin
      push(VEC_DATA[i]);
      check("R3 wptr", 64'(cfg_rdata[22:16]), 64'(VEC_WPTR[i]));
    end
    for (int i = 0; i < 8; i++) begin
      read_entry(7'(i), d);
      check("R3/R9 entry", d, VEC_DATA[i]);
    end

    // R5 freeze: offered data is refused
    cur_en = 1'b0;
    cfg_write(ctl(1'b0, 2'd0, 7'd0));
    check("R5 ready", 64'(ev_ready), 64'd0);
    @(negedge clk); ev_valid = 1'b1; ev_data = 64'hBAD0_BAD0_BAD0_BAD0;
    repeat (3) @(negedge clk);
    ev_valid = 1'b0;
    check("R5 wptr", 64'(cfg_rdata[22:16]), 64'd8);
    read_entry(7'd7, d);
    check("R5 entry7", d, VEC_DATA[7]);

    // R7 host write with status bits set
    cfg_write(32'h00FF_0000);
    check("R7 status", 64'(cfg_rdata[23:16]), 64'h88);

    // R6 resume
    cur_en = 1'b1;
    cfg_write(ctl(1'b1, 2'd0, 7'd8));
    push(64'hA5A5_0000_0000_0008);
    check("R6 wptr", 64'(cfg_rdata[22:16]), 64'd9);
    read_entry(7'd8, d);
    check("R6 entry8", d, 64'hA5A5_0000_0000_0008);

    // R8 wrap: 120 events fill 9..127 and 0
    for (int k = 0; k < 120; k++) push(64'hF000_0000_0000_0000 | 64'(k));
    check("R8 wptr", 64'(cfg_rdata[22:16]), 64'd1);
    read_entry(7'd0, d);
    check("R8 overwrite", d, 64'hF000_0000_0000_0077);
    read_entry(7'd127, d);
    check("R8 entry127", d, 64'hF000_0000_0000_0076);
    read_entry(7'd1, d);
    check("R8 oldest kept", d, VEC_DATA[1]);

    // R4 pair packing, mode 2
    cur_mode = 2'd2;
    cfg_write(ctl(1'b1, 2'd2, 7'd0));
    push(64'hDEAD_0000_AAAA_0001);
    check("R4 open flag", 64'(cfg_rdata[23]), 64'd0);
    check("R4 open wptr", 64'(cfg_rdata[22:16]), 64'd1);
    push(64'hDEAD_0000_BBBB_0002);
    check("R4 close flag", 64'(cfg_rdata[23]), 64'd1);
    check("R4 close wptr", 64'(cfg_rdata[22:16]), 64'd2);
    read_entry(7'd1, d);
    check("R4 entry1", d, 64'hBBBB_0002_AAAA_0001);

    // R10 incomplete entry: odd sample count
    push(64'h0000_0000_CCCC_0003);
    check("R10 incomplete", 64'({cfg_rdata[15:14], cfg_rdata[23]}), 64'b100);
    read_entry(7'(cfg_rdata[22:16] + 7'd1), d);
    check("R10 oldest", d, VEC_DATA[3]);
    read_entry(7'd2, d);
    check("R10 low half", 64'(d[31:0]), 64'h0000_0000_CCCC_0003);

    // R4/R7 switch to mode 3 keeps the open pair
    cur_mode = 2'd3;
    cfg_write(ctl(1'b1, 2'd3, 7'd2));
    check("R7 flag kept", 64'(cfg_rdata[23]), 64'd0);
    push(64'h0000_0000_DDDD_0004);
    check("R4 mode3 wptr", 64'(cfg_rdata[22:16]), 64'd3);
    check("R4 mode3 entry2", dat_rdata, 64'hDDDD_0004_CCCC_0003);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule